// File: doc/BRIEF.md
# Fixed-Timing Synchronous Bus Read

This block is a master and a memory slave joined by one clocked shared bus. Address and data travel on the same lines, and a read transaction runs on fixed cycle counts with no acknowledge. On a host start pulse the master raises a read request and puts the address on the shared lines. The slave waits out a fixed access time and then returns a data word on the same lines. The master captures that word and reports completion to the host.

The shared lines are modelled as a multiplexer driven by per-agent enables, so no tri-state logic is used. Each phase length is a parameter. The defaults are two address cycles, four access cycles and two data cycles. Correctness depends only on both sides counting the same cycles from the rise of the request.

Top module: `srb_read_top`

## Requirements
- R1: After a start is accepted, bus_req is high for exactly 8 consecutive cycles (the default 2 + 4 + 2) and then goes low.
- R2: In request cycles 1 and 2, only the master drives, and bus_data carries the host address latched at acceptance, zero-extended to the data width.
- R3: In request cycles 3 to 6, no agent drives, and bus_data reads as all zeros. bus_data also reads as zero in every cycle in which no agent drives.
- R4: In request cycles 7 and 8, only the slave drives, and bus_data carries the word (addr * 40503 + 23130) mod 2^16 for the latched address.
- R5: host_done is high for exactly one cycle, the first cycle after request cycle 8, with bus_req low. In that cycle host_rdata shows the word captured in cycle 8, and it holds that value until the next host_done.
- R6: In any cycle, at most one of bus_mst_drv and bus_slv_drv is high.
- R7: host_start is ignored while bus_req is high. Changes to host_addr after acceptance do not alter the address on the bus or the returned word.
- R8: A start seen in the host_done cycle is accepted. Back-to-back reads therefore keep bus_req low for exactly one cycle between them.
- R9: A synchronous active-low reset, including one during a transaction, leaves bus_req low, no driver enabled, host_done low and host_rdata zero in the cycle after the reset edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_start | input | 1 | Request a read (sampled when idle) |
| host_addr | input | AW | Read address |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | DW | Last word read |
| bus_req | output | 1 | Read request line |
| bus_data | output | DW | Shared address/data lines |
| bus_mst_drv | output | 1 | Master drives the shared lines |
| bus_slv_drv | output | 1 | Slave drives the shared lines |

## Verification
The hardest case is the boundary between transactions. A start can arrive in the exact cycle that host_done pulses, so bus_req falls and rises again with only one low cycle between. A start can also arrive in the middle of a read, together with a changed address that must have no effect. The stimulus holds host_start high across whole transactions to reach these cases, and it also asserts reset part-way through a read. A behavioural cycle model compares every bus and host output on every clock.

// File: rtl/srb_pkg.sv
// Package: shared phase encoding and the memory word function for the
// fixed-timing read bus. Assumes address width <= 32 bits.
package srb_pkg;

    // Master transaction phases
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_GAP  = 2'd2,
        PH_DATA = 2'd3
    } phase_e;

    // Contents of the modelled memory, computed from the address
    function automatic logic [31:0] word_of(input logic [31:0] a);
        return a * 32'd40503 + 32'd23130;
    endfunction

endpackage

// File: rtl/srb_bus.sv
// Shared address/data lines modelled as an enable-gated OR multiplexer.
// Assumes the agents keep their enables mutually exclusive. When no
// enable is high, the lines read as zero.
module srb_bus #(
    parameter int N  = 2,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  drv_en,
    input  logic [DW-1:0] drv_val [N],
    output logic [DW-1:0] bus
);
    logic [DW-1:0] gated [N];

    // Gate each agent's value by its own enable
    for (genvar i = 0; i < N; i++) begin : g_gate
        assign gated[i] = {DW{drv_en[i]}} & drv_val[i];
    end

    // Combine the gated values onto the lines
    always_comb begin
        bus = '0;
        for (int i = 0; i < N; i++) bus = bus | gated[i];
    end

    // R6
    single_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(drv_en) <= 1);
endmodule

// File: rtl/srb_master.sv
// Bus master: accepts a host start when idle, raises the read request,
// drives the latched address for ADDR_CYC cycles, waits GAP_CYC cycles,
// and captures the bus in the last of DATA_CYC data cycles. Assumes
// every phase count is at least 1 and AW <= DW.
module srb_master
    import srb_pkg::*;
#(
    parameter int AW       = 8,
    parameter int DW       = 16,
    parameter int ADDR_CYC = 2,
    parameter int GAP_CYC  = 4,
    parameter int DATA_CYC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] bus_in,
    output logic          req,
    output logic          drv_en,
    output logic [DW-1:0] drv_val,
    output logic          done,
    output logic [DW-1:0] rdata
);
    localparam int MAXC = (ADDR_CYC > GAP_CYC) ?
                          ((ADDR_CYC > DATA_CYC) ? ADDR_CYC : DATA_CYC) :
                          ((GAP_CYC  > DATA_CYC) ? GAP_CYC  : DATA_CYC);
    localparam int CW = $clog2(MAXC + 1);

    phase_e        phase;
    logic [CW-1:0] cnt;
    logic [AW-1:0] addr_q;

    // Phase sequencer with per-phase down counter and data capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            addr_q <= '0;
            done   <= 1'b0;
            rdata  <= '0;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase  <= PH_ADDR;
                        cnt    <= CW'(ADDR_CYC - 1);
                        addr_q <= addr;
                    end
                end
                PH_ADDR: begin
                    if (cnt == '0) begin
                        phase <= PH_GAP;
                        cnt   <= CW'(GAP_CYC - 1);
                    end else begin
                        cnt <= cnt - CW'(1);
                    end
                end
                PH_GAP: begin
                    if (cnt == '0) begin
                        phase <= PH_DATA;
                        cnt   <= CW'(DATA_CYC - 1);
                    end else begin
                        cnt <= cnt - CW'(1);
                    end
                end
                default: begin
                    if (cnt == '0) begin
                        phase <= PH_IDLE;
                        rdata <= bus_in;
                        done  <= 1'b1;
                    end else begin
                        cnt <= cnt - CW'(1);
                    end
                end
            endcase
        end
    end

    // Decode outputs from the phase
    assign req     = (phase != PH_IDLE);
    assign drv_en  = (phase == PH_ADDR);
    assign drv_val = DW'(addr_q);

    // R1
    req_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req) |-> done);
    // R2
    addr_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req) |-> drv_en);
    // R2
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_en && $past(drv_en)) |-> $stable(drv_val));
    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && $past(req)) |-> $stable(addr_q));
endmodule

// File: rtl/srb_slave.sv
// Memory slave: counts the cycles the read request is high, samples the
// address in the last address cycle, and drives the stored word during
// the data window. Assumes the master holds the request for exactly
// ADDR_CYC + GAP_CYC + DATA_CYC cycles.
module srb_slave
    import srb_pkg::*;
#(
    parameter int DW       = 16,
    parameter int ADDR_CYC = 2,
    parameter int GAP_CYC  = 4,
    parameter int DATA_CYC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic [DW-1:0] bus_in,
    output logic          drv_en,
    output logic [DW-1:0] drv_val
);
    localparam int TOTAL = ADDR_CYC + GAP_CYC + DATA_CYC;
    localparam int CW    = $clog2(TOTAL + 1);

    logic [CW-1:0] cnt;
    logic [DW-1:0] word_q;

    // Count request-high cycles, clear when the request is low
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (req) cnt <= cnt + CW'(1);
        else          cnt <= '0;
    end

    // Sample the address in the last address cycle and look up the word
    always_ff @(posedge clk) begin
        if (!rst_n)
            word_q <= '0;
        else if (req && cnt == CW'(ADDR_CYC - 1))
            word_q <= DW'(word_of(32'(bus_in)));
    end

    // Drive only inside the data window
    assign drv_en  = req && (cnt >= CW'(ADDR_CYC + GAP_CYC)) && (cnt < CW'(TOTAL));
    assign drv_val = word_q;

    // R4
    data_before_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req) |-> $past(drv_en));
    // R4
    word_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_en && $past(drv_en)) |-> $stable(drv_val));
endmodule

// File: rtl/srb_read_top.sv
// Top level: master and memory slave joined by the shared-line model.
// The bus lines and enables are brought out for observation.
module srb_read_top #(
    parameter int AW       = 8,
    parameter int DW       = 16,
    parameter int ADDR_CYC = 2,
    parameter int GAP_CYC  = 4,
    parameter int DATA_CYC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_start,
    input  logic [AW-1:0] host_addr,
    output logic          host_done,
    output logic [DW-1:0] host_rdata,
    output logic          bus_req,
    output logic [DW-1:0] bus_data,
    output logic          bus_mst_drv,
    output logic          bus_slv_drv
);
    localparam int NAG = 2;

    logic [NAG-1:0] en;
    logic [DW-1:0]  val [NAG];
    logic           req;
    logic [DW-1:0]  lines;

    srb_master #(.AW(AW), .DW(DW), .ADDR_CYC(ADDR_CYC),
                 .GAP_CYC(GAP_CYC), .DATA_CYC(DATA_CYC)) u_mst (
        .clk(clk), .rst_n(rst_n), .start(host_start), .addr(host_addr),
        .bus_in(lines), .req(req), .drv_en(en[0]), .drv_val(val[0]),
        .done(host_done), .rdata(host_rdata)
    );

    srb_slave #(.DW(DW), .ADDR_CYC(ADDR_CYC),
                .GAP_CYC(GAP_CYC), .DATA_CYC(DATA_CYC)) u_slv (
        .clk(clk), .rst_n(rst_n), .req(req), .bus_in(lines),
        .drv_en(en[1]), .drv_val(val[1])
    );

    srb_bus #(.N(NAG), .DW(DW)) u_bus (
        .clk(clk), .rst_n(rst_n), .drv_en(en), .drv_val(val), .bus(lines)
    );

    assign bus_req     = req;
    assign bus_data    = lines;
    assign bus_mst_drv = en[0];
    assign bus_slv_drv = en[1];
endmodule

// File: tb/srb_read_top_test.sv
module srb_read_top_test;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_start = 1'b0;
    logic [7:0]  host_addr = '0;
    logic        host_done, bus_req, bus_mst_drv, bus_slv_drv;
    logic [15:0] host_rdata, bus_data;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    srb_read_top uut (
        .clk(clk), .rst_n(rst_n), .host_start(host_start), .host_addr(host_addr),
        .host_done(host_done), .host_rdata(host_rdata), .bus_req(bus_req),
        .bus_data(bus_data), .bus_mst_drv(bus_mst_drv), .bus_slv_drv(bus_slv_drv)
    );

    always #(PERIOD/2) clk = ~clk;

    function automatic logic [15:0] mem(input logic [7:0] a);
        int unsigned v;
        v = int'(a) * 40503 + 23130;
        return v[15:0];
    endfunction

    // Reference model: t = request cycle index (0 = idle)
    int          t = 0;
    logic [7:0]  ref_addr = '0;
    logic        ref_done = 1'b0;
    logic [15:0] ref_rdata = '0;

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            t = 0; ref_done = 1'b0; ref_rdata = '0;
        end else begin
            ref_done = 1'b0;
            if (t == 0) begin
                if (host_start) begin t = 1; ref_addr = host_addr; end
            end else if (t == 8) begin
                t = 0; ref_done = 1'b1; ref_rdata = mem(ref_addr);
            end else begin
                t++;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s t=%0d actual=%h expected=%h", tag, t, act, exp);
        end
    endtask

    // Compare every cycle away from the active edge
    always @(negedge clk) begin
        logic [15:0] eb;
        eb = (t == 1 || t == 2) ? {8'h00, ref_addr} :
             (t == 7 || t == 8) ? mem(ref_addr) : 16'h0000;
        chk(bus_req == (t != 0), "R1 req", 16'(bus_req), 16'(t != 0));
        chk(bus_mst_drv == (t == 1 || t == 2), "R2 master drive", 16'(bus_mst_drv), 16'(t == 1 || t == 2));
        chk(bus_slv_drv == (t == 7 || t == 8), "R4 slave drive", 16'(bus_slv_drv), 16'(t == 7 || t == 8));
        chk(bus_data == eb, (t >= 3 && t <= 6) ? "R3 idle lines" : "R2/R4 bus value", bus_data, eb);
        chk(!(bus_mst_drv && bus_slv_drv), "R6 one driver", {bus_mst_drv, bus_slv_drv}, 16'h0);
        chk(host_done == ref_done, "R5 done", 16'(host_done), 16'(ref_done));
        chk(host_rdata == ref_rdata, rst_n ? "R5 rdata" : "R9 reset rdata", host_rdata, ref_rdata);
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    // One isolated read
    task automatic read1(input logic [7:0] a);
        host_addr = a; host_start = 1'b1;
        step(1);
        host_start = 1'b0;
        step(10);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(2);
        read1(8'h00);
        read1(8'hFF);
        read1(8'h5A);
        // R7: start held and address changed while busy
        host_addr = 8'h3C; host_start = 1'b1;
        step(2);
        host_addr = 8'hC3;
        step(5);
        host_start = 1'b0;
        step(4);
        // R8: back-to-back reads with start held high
        host_addr = 8'h81; host_start = 1'b1;
        step(9);
        host_addr = 8'h7E;
        step(9);
        host_start = 1'b0;
        step(12);
        // R9: reset in the middle of a read
        host_addr = 8'h11; host_start = 1'b1;
        step(1);
        host_start = 1'b0;
        step(4);
        rst_n = 1'b0;
        step(2);
        rst_n = 1'b1;
        step(2);
        read1(8'hA5);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        #(PERIOD * 5000);
        errors++; checks++;
        $display("FAIL watchdog expired actual=%0d expected=<5000 cycles", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule